// File: doc/BRIEF.md
# Receive Frame Statistics Counters

This block keeps the receive-side statistics of a network port. Once per frame the receive path gives it a one-cycle report: the frame length without the FCS, the length with the FCS, a class code, and two control bits. The large-frame bit raises the size limit. The keep-bad-frames bit turns off the size check. From the report the block picks a size bin and decides whether the frame is too large. It then updates its packet, octet, class and oversize counters, and for an oversized frame it raises a drop indication.

Software reads the counters through a small register port, one read per cycle. A read clears the counter it reads. The two wide octet counters are read in two steps: reading the low half clears the whole counter and keeps a copy of its high half, and that copy is then returned by the high-half read. Every counter stops at its all-ones value and never wraps.

Top module: `rx_stat_top`

## Requirements
- R1: The length including FCS picks at most one size bin: bin 0 is exactly 64, bin 1 is 65..127, bin 2 is 128..255, bin 3 is 256..511, bin 4 is 512..1023, and bin 5 is 1024 and above. A length below 64 counts in no bin. The bin counters sit at read addresses 0 to 5.
- R2: Every CNT_W-bit counter stops at 2^CNT_W-1. Further increments leave it at that value.
- R3: Each accepted (not oversized) frame increments the total-packet counter (address 6) and the good-packet counter (address 7).
- R4: The total-octet and good-octet counters are 2*CNT_W bits wide. Each accepted frame adds its length without FCS plus 4 to both. Both stop at 2^(2*CNT_W)-1.
- R5: Class code 2 (broadcast) increments the broadcast counter (address 8). Class code 1 (multicast) increments the multicast counter (address 9). Codes 0 and 3 (unicast) change neither counter.
- R6: A frame is oversized when its length without FCS is above 16384, or above 1522 while the large-frame bit is 0. While the keep-bad-frames bit is 1, no frame is oversized.
- R7: For an oversized frame, drop_o is 1 in the cycle after the report and the oversize counter (address 10) increments. For any other report, drop_o is 0 in that cycle.
- R8: An oversized frame changes no bin, packet, octet or class counter.
- R9: A read with rd_en_i high returns the addressed value on rd_data_o in the next cycle and clears that counter. All counters read 0 after reset.
- R10: Address 11 (total) and address 13 (good) return the low CNT_W bits of an octet counter. The read clears the whole counter and copies its high half into a hold register. Address 12 (total) and address 14 (good) return that hold register and clear it.
- R11: A read in the same cycle as a frame report returns the value before the frame. The frame's update is then applied on top of the cleared counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rpt_valid_i | input | 1 | Frame report present this cycle |
| rpt_len_i | input | LEN_W | Frame length without FCS |
| rpt_len_fcs_i | input | LEN_W | Frame length with FCS |
| rpt_cls_i | input | 2 | Class: 0 unicast, 1 multicast, 2 broadcast, 3 unicast |
| rpt_lpe_i | input | 1 | Large-frame enable |
| rpt_sbp_i | input | 1 | Keep-bad-frames; turns off the size check |
| drop_o | output | 1 | Previous report was oversized |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | CNT_W | Read data, one cycle after the strobe |

## Verification
The bench sweeps every length across the lower bins, so that a bin edge off by one shows up as a count in the wrong bin or a short frame counted in bin 0. It tries each combination of the two control bits at both size limits, each length tested from just below to just above the limit. This catches a design that uses the wrong length, a strict-versus-inclusive comparison, or a keep-bad-frames bit that does not override. Enough frames are sent to push the packet counters and then the octet counters past their all-ones value, which exposes wrapping or a carry that is lost. It also puts reads in the same cycle as updates and reads the two octet halves in order. A design that returned the updated value, dropped the update, or failed to latch the high half would report wrong numbers.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;

    typedef enum logic [1:0] {
        CLS_UNICAST   = 2'd0,
        CLS_MULTICAST = 2'd1,
        CLS_BROADCAST = 2'd2,
        CLS_OTHER     = 2'd3
    } frame_cls_e;

    localparam int NUM_BINS  = 6;
    localparam int IDX_TOTAL = 6;
    localparam int IDX_GOOD  = 7;
    localparam int IDX_BCAST = 8;
    localparam int IDX_MCAST = 9;
    localparam int IDX_OVER  = 10;
    localparam int NUM_CNT   = 11;

    localparam int ADDR_W       = 4;
    localparam int ADDR_TOT_LO  = 11;
    localparam int ADDR_TOT_HI  = 12;
    localparam int ADDR_GOOD_LO = 13;
    localparam int ADDR_GOOD_HI = 14;

endpackage

// File: rtl/rx_stat_classify.sv
module rx_stat_classify
    import rx_stat_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int STD_MAX   = 1522,
    parameter int JUMBO_MAX = 16384
) (
    input  logic [LEN_W-1:0]    len_i,
    input  logic [LEN_W-1:0]    len_fcs_i,
    input  logic                lpe_i,
    input  logic                sbp_i,
    output logic [NUM_BINS-1:0] bin_o,
    output logic                oversize_o
);

    localparam logic [LEN_W-1:0] STD_LIM   = LEN_W'(STD_MAX);
    localparam logic [LEN_W-1:0] JUMBO_LIM = LEN_W'(JUMBO_MAX);

    // Bin k covers [LO, HI]; bin 0 is a single length, the last bin is open above.
    for (genvar k = 0; k < NUM_BINS; k++) begin : g_bin
        localparam int LO = (k == 0) ? 64 : (k == 1) ? 65 : (64 << (k - 1));
        localparam int HI = (k == 0) ? 64 : (64 << k) - 1;
        if (k == NUM_BINS - 1) begin : g_open
            assign bin_o[k] = (len_fcs_i >= LEN_W'(LO));
        end else begin : g_closed
            assign bin_o[k] = (len_fcs_i >= LEN_W'(LO)) && (len_fcs_i <= LEN_W'(HI));
        end
    end

    always_comb begin
        oversize_o = !sbp_i && ((len_i > JUMBO_LIM) || (!lpe_i && (len_i > STD_LIM)));
    end

endmodule

// File: rtl/rx_stat_cnt_bank.sv
module rx_stat_cnt_bank #(
    parameter int N = 11,
    parameter int W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          inc_i,
    input  logic [N-1:0]          clr_i,
    output logic [N-1:0][W-1:0]   cnt_o
);

    localparam logic [W-1:0] CNT_MAX = '1;

    logic [N-1:0][W-1:0] cnt_d, cnt_q;

    always_comb begin
        logic [W-1:0] base_v;
        for (int i = 0; i < N; i++) begin
            base_v   = clr_i[i] ? '0 : cnt_q[i];
            cnt_d[i] = (inc_i[i] && (base_v != CNT_MAX)) ? base_v + 1'b1 : base_v;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        p_sat_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[i] == CNT_MAX && !clr_i[i]) |=> cnt_q[i] == CNT_MAX);
        p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !inc_i[i]) |=> cnt_q[i] == '0);
        p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[i] && cnt_q[i] != CNT_MAX) |=>
                cnt_q[i] == $past(cnt_q[i]) + W'($past(inc_i[i])));
    end

endmodule

// File: rtl/rx_stat_octet_acc.sv
module rx_stat_octet_acc #(
    parameter int HALF_W = 32,
    parameter int ADD_W  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_en_i,
    input  logic [ADD_W-1:0]  add_val_i,
    input  logic              rd_lo_i,
    input  logic              rd_hi_i,
    output logic [HALF_W-1:0] lo_o,
    output logic [HALF_W-1:0] hi_o
);

    localparam int FULL_W = 2 * HALF_W;

    typedef struct packed {
        logic [FULL_W-1:0] acc;
        logic [HALF_W-1:0] hold;
    } oct_state_t;

    oct_state_t st_d, st_q;

    always_comb begin
        logic [FULL_W-1:0] base_v;
        logic [FULL_W:0]   sum_v;
        st_d   = st_q;
        base_v = rd_lo_i ? '0 : st_q.acc;
        sum_v  = {1'b0, base_v} + {{(FULL_W + 1 - ADD_W){1'b0}}, add_val_i};
        if (add_en_i) st_d.acc = sum_v[FULL_W] ? '1 : sum_v[FULL_W-1:0];
        else          st_d.acc = base_v;
        if (rd_lo_i)      st_d.hold = st_q.acc[FULL_W-1:HALF_W];
        else if (rd_hi_i) st_d.hold = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lo_o = st_q.acc[HALF_W-1:0];
    assign hi_o = st_q.hold;

    p_oct_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.acc == '1 && !rd_lo_i) |=> st_q.acc == '1);
    p_oct_grow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en_i && !rd_lo_i) |=> st_q.acc >= $past(st_q.acc));
    p_hold_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo_i |=> st_q.hold == $past(st_q.acc[FULL_W-1:HALF_W]));

endmodule

// File: rtl/rx_stat_top.sv
module rx_stat_top
    import rx_stat_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int LEN_W     = 16,
    parameter int STD_MAX   = 1522,
    parameter int JUMBO_MAX = 16384
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rpt_valid_i,
    input  logic [LEN_W-1:0]  rpt_len_i,
    input  logic [LEN_W-1:0]  rpt_len_fcs_i,
    input  logic [1:0]        rpt_cls_i,
    input  logic              rpt_lpe_i,
    input  logic              rpt_sbp_i,
    output logic              drop_o,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [CNT_W-1:0]  rd_data_o
);

    localparam int ADD_W = LEN_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] rd_data;
        logic             drop;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [NUM_BINS-1:0]           bin_oh;
    logic                          oversize;
    logic                          accept;
    logic [NUM_CNT-1:0]            cnt_inc, cnt_clr;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;
    logic [ADD_W-1:0]              oct_add;
    logic [CNT_W-1:0]              tot_lo, tot_hi, good_lo, good_hi;
    frame_cls_e                    cls;

    rx_stat_classify #(
        .LEN_W(LEN_W), .STD_MAX(STD_MAX), .JUMBO_MAX(JUMBO_MAX)
    ) u_classify (
        .len_i(rpt_len_i), .len_fcs_i(rpt_len_fcs_i),
        .lpe_i(rpt_lpe_i), .sbp_i(rpt_sbp_i),
        .bin_o(bin_oh), .oversize_o(oversize)
    );

    always_comb begin
        cls     = frame_cls_e'(rpt_cls_i);
        accept  = rpt_valid_i && !oversize;
        oct_add = {1'b0, rpt_len_i} + ADD_W'(4);
        cnt_inc = '0;
        for (int b = 0; b < NUM_BINS; b++) cnt_inc[b] = accept && bin_oh[b];
        cnt_inc[IDX_TOTAL] = accept;
        cnt_inc[IDX_GOOD]  = accept;
        cnt_inc[IDX_BCAST] = accept && (cls == CLS_BROADCAST);
        cnt_inc[IDX_MCAST] = accept && (cls == CLS_MULTICAST);
        cnt_inc[IDX_OVER]  = rpt_valid_i && oversize;
        for (int i = 0; i < NUM_CNT; i++)
            cnt_clr[i] = rd_en_i && (rd_addr_i == ADDR_W'(i));
    end

    rx_stat_cnt_bank #(.N(NUM_CNT), .W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc_i(cnt_inc), .clr_i(cnt_clr), .cnt_o(cnt_all)
    );

    rx_stat_octet_acc #(.HALF_W(CNT_W), .ADD_W(ADD_W)) u_oct_total (
        .clk(clk), .rst_n(rst_n), .add_en_i(accept), .add_val_i(oct_add),
        .rd_lo_i(rd_en_i && rd_addr_i == ADDR_W'(ADDR_TOT_LO)),
        .rd_hi_i(rd_en_i && rd_addr_i == ADDR_W'(ADDR_TOT_HI)),
        .lo_o(tot_lo), .hi_o(tot_hi)
    );

    rx_stat_octet_acc #(.HALF_W(CNT_W), .ADD_W(ADD_W)) u_oct_good (
        .clk(clk), .rst_n(rst_n), .add_en_i(accept), .add_val_i(oct_add),
        .rd_lo_i(rd_en_i && rd_addr_i == ADDR_W'(ADDR_GOOD_LO)),
        .rd_hi_i(rd_en_i && rd_addr_i == ADDR_W'(ADDR_GOOD_HI)),
        .lo_o(good_lo), .hi_o(good_hi)
    );

    always_comb begin
        st_d      = st_q;
        st_d.drop = rpt_valid_i && oversize;
        if (rd_en_i) begin
            st_d.rd_data = '0;
            for (int i = 0; i < NUM_CNT; i++)
                if (rd_addr_i == ADDR_W'(i)) st_d.rd_data = cnt_all[i];
            case (int'(rd_addr_i))
                ADDR_TOT_LO:  st_d.rd_data = tot_lo;
                ADDR_TOT_HI:  st_d.rd_data = tot_hi;
                ADDR_GOOD_LO: st_d.rd_data = good_lo;
                ADDR_GOOD_HI: st_d.rd_data = good_hi;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drop_o    = st_q.drop;
    assign rd_data_o = st_q.rd_data;

    p_bin_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid_i |-> $onehot0(bin_oh));
    p_sbp_no_over_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid_i && rpt_sbp_i) |-> !oversize);
    p_drop_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid_i && oversize) |=> drop_o);
    p_over_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid_i && oversize && !rd_en_i) |=>
            cnt_all[IDX_GOOD] == $past(cnt_all[IDX_GOOD]));
    p_read_old_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_addr_i == ADDR_W'(IDX_TOTAL)) |=>
            rd_data_o == $past(cnt_all[IDX_TOTAL]));

endmodule

// File: tb/tb_rx_stat_top.sv
module tb_rx_stat_top;

    localparam int CNT_W = 12;
    localparam int LEN_W = 16;
    localparam longint CMAX = (64'd1 << CNT_W) - 1;
    localparam longint OMAX = (64'd1 << (2 * CNT_W)) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rpt_valid_i = 1'b0;
    logic [LEN_W-1:0]  rpt_len_i = '0;
    logic [LEN_W-1:0]  rpt_len_fcs_i = '0;
    logic [1:0]        rpt_cls_i = '0;
    logic              rpt_lpe_i = 1'b0;
    logic              rpt_sbp_i = 1'b0;
    logic              drop_o;
    logic              rd_en_i = 1'b0;
    logic [3:0]        rd_addr_i = '0;
    logic [CNT_W-1:0]  rd_data_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    longint exp_cnt [11];
    longint exp_tot, exp_good, hold_tot, hold_good;

    always #2 clk = ~clk;

    rx_stat_top #(.CNT_W(CNT_W), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .rpt_valid_i(rpt_valid_i), .rpt_len_i(rpt_len_i),
        .rpt_len_fcs_i(rpt_len_fcs_i), .rpt_cls_i(rpt_cls_i), .rpt_lpe_i(rpt_lpe_i),
        .rpt_sbp_i(rpt_sbp_i), .drop_o(drop_o), .rd_en_i(rd_en_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
    );

    task automatic check(string tag, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint sat_inc(longint v);
        return (v >= CMAX) ? CMAX : v + 1;
    endfunction

    function automatic longint sat_add(longint v, longint a);
        return (v + a > OMAX) ? OMAX : v + a;
    endfunction

    // Expected effect of one report (R1, R3, R4, R5, R6, R7, R8).
    function automatic bit model_frame(int len, int cls, bit lpe, bit sbp);
        int lf = len + 4;
        bit over = !sbp && (len > 16384 || (!lpe && len > 1522));
        int bin = -1;
        if (over) begin
            exp_cnt[10] = sat_inc(exp_cnt[10]);
            return 1'b1;
        end
        if (lf == 64) bin = 0;
        else if (lf >= 65 && lf <= 127) bin = 1;
        else if (lf >= 128 && lf <= 255) bin = 2;
        else if (lf >= 256 && lf <= 511) bin = 3;
        else if (lf >= 512 && lf <= 1023) bin = 4;
        else if (lf >= 1024) bin = 5;
        if (bin >= 0) exp_cnt[bin] = sat_inc(exp_cnt[bin]);
        exp_cnt[6] = sat_inc(exp_cnt[6]);
        exp_cnt[7] = sat_inc(exp_cnt[7]);
        if (cls == 2) exp_cnt[8] = sat_inc(exp_cnt[8]);
        if (cls == 1) exp_cnt[9] = sat_inc(exp_cnt[9]);
        exp_tot  = sat_add(exp_tot, lf);
        exp_good = sat_add(exp_good, lf);
        return 1'b0;
    endfunction

    // Expected read value with clear-on-read (R9, R10).
    function automatic longint model_read(int addr);
        longint v = 0;
        if (addr < 11) begin
            v = exp_cnt[addr];
            exp_cnt[addr] = 0;
        end else if (addr == 11) begin
            v = exp_tot & CMAX; hold_tot = exp_tot >> CNT_W; exp_tot = 0;
        end else if (addr == 12) begin
            v = hold_tot; hold_tot = 0;
        end else if (addr == 13) begin
            v = exp_good & CMAX; hold_good = exp_good >> CNT_W; exp_good = 0;
        end else if (addr == 14) begin
            v = hold_good; hold_good = 0;
        end
        return v;
    endfunction

    function automatic string addr_tag(int addr);
        if (addr <= 5) return "R1";
        if (addr <= 7) return "R3";
        if (addr <= 9) return "R5";
        if (addr == 10) return "R7";
        if (addr == 11 || addr == 13) return "R4";
        return "R10";
    endfunction

    // Called at a negedge; returns at the following negedge.
    task automatic cycle(bit fv, int len, int cls, bit lpe, bit sbp,
                         bit rv, int addr, string tag);
        bit over = 1'b0;
        longint rexp = 0;
        rpt_valid_i   = fv;
        rpt_len_i     = LEN_W'(len);
        rpt_len_fcs_i = LEN_W'(len + 4);
        rpt_cls_i     = 2'(cls);
        rpt_lpe_i     = lpe;
        rpt_sbp_i     = sbp;
        rd_en_i       = rv;
        rd_addr_i     = 4'(addr);
        if (rv) rexp = model_read(addr);   // read sees pre-update value (R11)
        if (fv) over = model_frame(len, cls, lpe, sbp);
        @(negedge clk);
        if (fv) check((tag.len() != 0) ? tag : "R7", longint'(drop_o), longint'(over));
        if (rv) check((tag.len() != 0) ? tag : addr_tag(addr), longint'(rd_data_o), rexp);
        rpt_valid_i = 1'b0;
        rd_en_i     = 1'b0;
    endtask

    task automatic frame(int len, int cls, bit lpe, bit sbp, string tag);
        cycle(1'b1, len, cls, lpe, sbp, 1'b0, 0, tag);
    endtask

    task automatic rd(int addr, string tag);
        cycle(1'b0, 0, 0, 1'b0, 1'b0, 1'b1, addr, tag);
    endtask

    task automatic read_all(string tag);
        for (int a = 0; a < 15; a++) rd(a, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog (all requirements) actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 11; i++) exp_cnt[i] = 0;
        exp_tot = 0; exp_good = 0; hold_tot = 0; hold_good = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R9: all counters zero after reset
        read_all("R9");

        // R1/R3/R4/R5: every length across the lower bins, all class codes
        for (int len = 0; len <= 1100; len++) frame(len, len % 4, len[1], 1'b0, "");
        read_all("");
        // R9/R10: a second pass must find everything cleared
        read_all("R9");

        // R6: limits at both edges with all control combinations
        for (int len = 1518; len <= 1526; len++)
            for (int c = 0; c < 4; c++) frame(len, 2, c[0], c[1], "R6");
        for (int len = 16380; len <= 16390; len++)
            for (int c = 0; c < 4; c++) frame(len, 1, c[0], c[1], "R6");
        read_all("");

        // R8: only oversized frames, nothing but the oversize counter moves
        for (int k = 0; k < 5; k++) frame(2000 + k, 2, 1'b0, 1'b0, "R7");
        for (int k = 0; k < 3; k++) frame(20000, 1, 1'b1, 1'b0, "R7");
        read_all("R8");

        // R11: read and update in the same cycle
        for (int k = 0; k < 3; k++) frame(200, 0, 1'b0, 1'b0, "");
        cycle(1'b1, 200, 2, 1'b0, 1'b0, 1'b1, 2, "R11");
        rd(2, "R11");
        cycle(1'b1, 300, 1, 1'b0, 1'b0, 1'b1, 8, "R11");
        rd(8, "R11");
        for (int k = 0; k < 20; k++) frame(1400, 0, 1'b0, 1'b0, "");
        cycle(1'b1, 900, 0, 1'b0, 1'b0, 1'b1, 11, "R11");
        rd(12, "R10");
        rd(11, "R11");
        rd(12, "R10");
        read_all("");

        // R2: packet-style counters stop at all-ones
        for (int k = 0; k < 4100; k++) frame(60, 2, 1'b0, 1'b0, "");
        for (int k = 0; k < 4100; k++) frame(2000, 0, 1'b0, 1'b0, "");
        read_all("R2");

        // R4: octet counters stop at all-ones, then R10 halves
        for (int k = 0; k < 1100; k++) frame(16000, 0, 1'b1, 1'b0, "");
        rd(11, "R4");
        rd(12, "R4");
        rd(12, "R10");
        rd(13, "R4");
        rd(14, "R4");
        rd(14, "R10");
        read_all("R9");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule